// File: doc/BRIEF.md
# Link Negotiation Controller

This block sits on the management side of a Fast-Ethernet transceiver. It decides how the link comes up, at which speed and duplex. It holds four 16-bit registers that are reached through a plain register port: control, local abilities, partner abilities and negotiation status. Its state machine runs the restart sequence: a long quiet wait, then a search for the partner. The search ends in one of three ways: a negotiated link, a link found by parallel detection, or forced operation chosen by software.

The signal-processing front end reports what it sees through level inputs:
- a fast-link-pulse burst that carries a partner ability word;
- 100M idle symbols;
- 10M link pulses;
- signal present;
- a parallel-detection fault.

The block drives the resolved speed and duplex, a link flag and a traffic-enable flag. The traffic-enable flag gates the transmit and receive data paths. There is no streaming data at this block's edge, so every pin is plain control or status and none of them uses a valid/ready handshake.

Register map (2-bit address):
- 0: control. Bit 13 is the forced speed (1 = 100M). Bit 12 enables negotiation. Bit 9 requests a restart. Bit 8 is the forced duplex (1 = full).
- 1: local abilities. Bits [8:5] are writable. Bits [4:0] read 00001. All other bits read 0.
- 2: partner abilities (read-only).
- 3: status (read-only). Bit 0 means the partner negotiated. Bit 4 is a sticky parallel-detect fault.

Ability bit 5 is 10M half, bit 6 is 10M full, bit 7 is 100M half and bit 8 is 100M full.

Top module: `an_ctrl_top`

## Requirements
- R1: After reset, the registers read as follows: control 0x3000, abilities 0x01E1, partner 0x0000, status 0x0000. At the same time link_up and traffic_en are 0.
- R2: A write to address 1 stores only wdata[8:5]. It does not restart negotiation, and an established link keeps its speed and duplex.
- R3: A control write with bit 12 = 1 and bit 9 = 1 sets bit 9. Bit 9 reads 1 for exactly one cycle and then self-clears as the restart begins. The restart copies the stored abilities into the set used for resolution.
- R4: A restart holds the block in a break wait of BREAK_CYCLES cycles. The break wait begins the cycle after bit 9 is set. During it, link_up and traffic_en are 0 and all line inputs are ignored.
- R5: When a pulse word is seen after the break wait, the link comes up with the highest ability that both sides share. The order from highest is 100 full, 100 half, 10 full, 10 half. With no shared ability the link stays down.
- R6: A received pulse word is stored in the partner register with bit 15 forced to 0, and status bit 0 is set.
- R7: Parallel detection applies when there is no pulse word and no fault. With 100M idle symbols seen, the link comes up at 100M half duplex and the partner register reads 0x0080. Otherwise, with 10M link pulses seen, it comes up at 10M half duplex and the partner register reads 0x0020. Idle symbols win when both are present. Status bit 0 is cleared.
- R8: A parallel-detect fault with no pulse word keeps the link down and sets status bit 4. The bit stays set until the next restart clears it.
- R9: Losing signal_present while the link is up starts a new break wait, exactly as a restart does.
- R10: A control write with bit 12 = 0 enters forced mode on the next cycle. In forced mode speed_100 follows bit 13, full_duplex follows bit 8, and link_up and traffic_en follow signal_present.
- R11: A control write with bit 12 = 1 while in forced mode restarts negotiation, even if bit 9 is 0.
- R12: While negotiation is enabled, control bits 13 and 8 have no effect on speed_100 or full_duplex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register (combinational) |
| flp_valid | input | 1 | Fast-link-pulse word present |
| flp_word | input | 16 | Partner ability word from the pulses |
| idle100_seen | input | 1 | 100M idle symbols detected |
| nlp10_seen | input | 1 | 10M link pulses detected |
| signal_present | input | 1 | Received signal present |
| pd_fault | input | 1 | Fault during parallel detection |
| link_up | output | 1 | Link established |
| speed_100 | output | 1 | 1 = 100M, 0 = 10M |
| full_duplex | output | 1 | 1 = full duplex |
| traffic_en | output | 1 | Data path may transmit and receive |

## Verification
The bench builds the block with BREAK_CYCLES set to 16 instead of the default of about 30 million. This makes every restart cost only about twenty cycles, so dozens of restarts fit in one run. With such short restarts, the bench can sample the exact last quiet cycle and the first link cycle around each break wait. It can also sweep random ability pairs and random parallel-detection input mixes, each behind its own restart.

// File: rtl/an_pkg.sv
package an_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned NABIL    = 4;
  localparam int unsigned ABIL_LSB = 5;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_ADV  = 2'd1;
  localparam logic [1:0] ADDR_LP   = 2'd2;
  localparam logic [1:0] ADDR_STAT = 2'd3;

  localparam int unsigned C_SPD = 13;
  localparam int unsigned C_EN  = 12;
  localparam int unsigned C_RST = 9;
  localparam int unsigned C_DUP = 8;

  localparam logic [4:0] ADV_SELECTOR = 5'b00001;

  // ability index: bit1 = 100M, bit0 = full duplex
  typedef enum logic [1:0] {ST_BREAK, ST_DETECT, ST_LINK, ST_FORCED} an_state_e;

  typedef struct packed {
    logic ok;
    logic spd100;
    logic fdx;
  } an_res_t;
endpackage

// File: rtl/an_break_timer.sv
module an_break_timer #(
  parameter int unsigned CYCLES = 30_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic done
);
  localparam int unsigned CW = $clog2(CYCLES) + 1;
  localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= LOAD;
      run <= 1'b1;
    end else if (start) begin
      cnt <= LOAD;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end

  assign done = run && (cnt == '0);
endmodule

// File: rtl/an_resolve.sv
module an_resolve
  import an_pkg::*;
(
  input  logic [NABIL-1:0] ours,
  input  logic [NABIL-1:0] theirs,
  output an_res_t          res
);
  logic [NABIL-1:0] common;
  assign common = ours & theirs;

  // scan upward so the highest shared ability wins
  always_comb begin
    res = '0;
    for (int i = 0; i < NABIL; i++) begin
      if (common[i]) begin
        res.ok     = 1'b1;
        res.spd100 = i[1];
        res.fdx    = i[0];
      end
    end
  end
endmodule

// File: rtl/an_ctrl_top.sv
module an_ctrl_top
  import an_pkg::*;
#(
  parameter int unsigned BREAK_CYCLES = 30_000_000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  reg_addr,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        flp_valid,
  input  logic [15:0] flp_word,
  input  logic        idle100_seen,
  input  logic        nlp10_seen,
  input  logic        signal_present,
  input  logic        pd_fault,
  output logic        link_up,
  output logic        speed_100,
  output logic        full_duplex,
  output logic        traffic_en
);
  localparam int unsigned ABIL_MSB = ABIL_LSB + NABIL - 1;
  localparam logic [REG_W-1:0] LP_PD100 = REG_W'(1) << (ABIL_LSB + 2);
  localparam logic [REG_W-1:0] LP_PD10  = REG_W'(1) << ABIL_LSB;

  an_state_e         state;
  logic              ctrl_an_en, ctrl_spd, ctrl_dup, ctrl_rst;
  logic [NABIL-1:0]  adv_sw, adv_live;
  logic [REG_W-1:0]  lp_reg;
  logic              stat_lp_an, stat_pd_fault;
  logic              res_spd, res_dup;
  an_res_t           res;
  logic              brk_done;

  logic wr_ctrl, wr_adv, restart_req, force_req, go_break;
  logic unused_bits;

  assign wr_ctrl     = reg_wr && (reg_addr == ADDR_CTRL);
  assign wr_adv      = reg_wr && (reg_addr == ADDR_ADV);
  assign restart_req = wr_ctrl && reg_wdata[C_EN] && (reg_wdata[C_RST] || !ctrl_an_en);
  assign force_req   = wr_ctrl && !reg_wdata[C_EN];
  assign go_break    = !force_req &&
                       (ctrl_rst || (state == ST_LINK && !signal_present));
  assign unused_bits = ^{reg_wdata[15:14], reg_wdata[11:10], reg_wdata[4:0], flp_word[15]};

  an_break_timer #(.CYCLES(BREAK_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (go_break),
    .done  (brk_done)
  );

  an_resolve u_resolve (
    .ours   (adv_live),
    .theirs (flp_word[ABIL_MSB:ABIL_LSB]),
    .res    (res)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_BREAK;
      ctrl_an_en    <= 1'b1;
      ctrl_spd      <= 1'b1;
      ctrl_dup      <= 1'b0;
      ctrl_rst      <= 1'b0;
      adv_sw        <= '1;
      adv_live      <= '1;
      lp_reg        <= '0;
      stat_lp_an    <= 1'b0;
      stat_pd_fault <= 1'b0;
      res_spd       <= 1'b0;
      res_dup       <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        ctrl_an_en <= reg_wdata[C_EN];
        ctrl_spd   <= reg_wdata[C_SPD];
        ctrl_dup   <= reg_wdata[C_DUP];
      end
      ctrl_rst <= restart_req;
      if (wr_adv) adv_sw <= reg_wdata[ABIL_MSB:ABIL_LSB];

      if (force_req) begin
        state <= ST_FORCED;
      end else if (go_break) begin
        state         <= ST_BREAK;
        adv_live      <= adv_sw;
        stat_pd_fault <= 1'b0;
      end else begin
        case (state)
          ST_BREAK: if (brk_done) state <= ST_DETECT;
          ST_DETECT: begin
            if (flp_valid) begin
              lp_reg     <= {1'b0, flp_word[14:0]};
              stat_lp_an <= 1'b1;
              if (res.ok) begin
                state   <= ST_LINK;
                res_spd <= res.spd100;
                res_dup <= res.fdx;
              end
            end else if (pd_fault) begin
              stat_pd_fault <= 1'b1;
            end else if (idle100_seen || nlp10_seen) begin
              state      <= ST_LINK;
              res_spd    <= idle100_seen;
              res_dup    <= 1'b0;
              lp_reg     <= idle100_seen ? LP_PD100 : LP_PD10;
              stat_lp_an <= 1'b0;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign link_up     = (state == ST_LINK) || (state == ST_FORCED && signal_present);
  assign speed_100   = (state == ST_FORCED) ? ctrl_spd : res_spd;
  assign full_duplex = (state == ST_FORCED) ? ctrl_dup : res_dup;
  assign traffic_en  = link_up;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[C_SPD] = ctrl_spd;
        reg_rdata[C_EN]  = ctrl_an_en;
        reg_rdata[C_RST] = ctrl_rst;
        reg_rdata[C_DUP] = ctrl_dup;
      end
      ADDR_ADV: begin
        reg_rdata[ABIL_MSB:ABIL_LSB] = adv_sw;
        reg_rdata[4:0]               = ADV_SELECTOR;
      end
      ADDR_LP:   reg_rdata = lp_reg;
      default: begin
        reg_rdata[0] = stat_lp_an;
        reg_rdata[4] = stat_pd_fault;
      end
    endcase
  end
endmodule

// File: rtl/an_ctrl_checker.sv
module an_ctrl_checker
  import an_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input an_state_e   state,
  input logic        ctrl_rst,
  input logic        force_req,
  input logic        signal_present,
  input logic        flp_valid,
  input logic [15:0] flp_word,
  input logic        pd_fault,
  input logic        idle100_seen,
  input logic        nlp10_seen,
  input logic [3:0]  adv_live,
  input logic        reg_wr,
  input logic [1:0]  reg_addr,
  input logic [15:0] reg_rdata,
  input logic        link_up,
  input logic        traffic_en,
  input logic        full_duplex
);
  assert_break_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_BREAK |-> !link_up && !traffic_en);

  assert_restart_selfclear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_rst && !force_req |=> !ctrl_rst && state == ST_BREAK);

  assert_adv_no_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == ADDR_ADV && state == ST_LINK && signal_present && !ctrl_rst
    |=> state == ST_LINK);

  assert_no_common_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DETECT && flp_valid && !force_req && !ctrl_rst &&
    (adv_live & flp_word[8:5]) == 4'b0 |=> !link_up);

  assert_pd_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_DETECT && !flp_valid && !pd_fault && (idle100_seen || nlp10_seen) &&
    !force_req && !ctrl_rst |=> link_up && !full_duplex);

  assert_lp_np_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == ADDR_LP |-> !reg_rdata[15]);

  assert_sigloss_break_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LINK && !signal_present && !force_req |=> state == ST_BREAK);

  assert_force_enter_R10: assert property (@(posedge clk) disable iff (!rst_n)
    force_req |=> state == ST_FORCED);
endmodule

bind an_ctrl_top an_ctrl_checker chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .state          (state),
  .ctrl_rst       (ctrl_rst),
  .force_req      (force_req),
  .signal_present (signal_present),
  .flp_valid      (flp_valid),
  .flp_word       (flp_word),
  .pd_fault       (pd_fault),
  .idle100_seen   (idle100_seen),
  .nlp10_seen     (nlp10_seen),
  .adv_live       (adv_live),
  .reg_wr         (reg_wr),
  .reg_addr       (reg_addr),
  .reg_rdata      (reg_rdata),
  .link_up        (link_up),
  .traffic_en     (traffic_en),
  .full_duplex    (full_duplex)
);

// File: tb/an_ctrl_top_tb_top.sv
`timescale 1ns/1ps
module an_ctrl_top_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        flp_valid = 1'b0;
  logic [15:0] flp_word = 16'h0;
  logic        idle100_seen = 1'b0;
  logic        nlp10_seen = 1'b0;
  logic        signal_present = 1'b0;
  logic        pd_fault = 1'b0;
  logic        link_up, speed_100, full_duplex, traffic_en;

  int n_tests = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  an_ctrl_top #(.BREAK_CYCLES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flp_valid(flp_valid),
    .flp_word(flp_word), .idle100_seen(idle100_seen), .nlp10_seen(nlp10_seen),
    .signal_present(signal_present), .pd_fault(pd_fault), .link_up(link_up),
    .speed_100(speed_100), .full_duplex(full_duplex), .traffic_en(traffic_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // highest shared ability: {ok, 100M, full}
  function automatic logic [2:0] expect_res(input logic [3:0] ours, input logic [3:0] theirs);
    logic [3:0] c;
    c = ours & theirs;
    if (c[3]) return 3'b111;
    if (c[2]) return 3'b110;
    if (c[1]) return 3'b101;
    if (c[0]) return 3'b100;
    return 3'b000;
  endfunction

  task automatic restart_and_wait();
    wr(2'd0, 16'h1200);
    tick(N + 3);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [2:0]  e;
    logic [3:0]  adv;
    logic [15:0] w;
    int seed_val;
    seed_val = $urandom(32'h1A2B3C);

    tick(3);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(2'd0, d); chk("R1 ctrl", d, 16'h3000);
    rd(2'd1, d); chk("R1 adv", d, 16'h01E1);
    rd(2'd2, d); chk("R1 partner", d, 16'h0000);
    rd(2'd3, d); chk("R1 status", d, 16'h0000);
    chk("R1 link", link_up, 0);
    chk("R1 traffic", traffic_en, 0);

    // R6 / R5: first negotiation out of reset, bit15 masked
    signal_present = 1'b1;
    flp_word = 16'h81E1; flp_valid = 1'b1;
    tick(N + 3);
    chk("R5 link 100F", {link_up, speed_100, full_duplex}, 3'b111);
    rd(2'd2, d); chk("R6 partner masked", d, 16'h01E1);
    rd(2'd3, d); chk("R6 status bit0", d, 16'h0001);

    // R12: forced bits ignored while negotiating
    wr(2'd0, 16'h1000);
    tick(2);
    chk("R12 speed/duplex kept", {link_up, speed_100, full_duplex}, 3'b111);

    // R2: ability write, no restart
    wr(2'd1, 16'hFE3F);
    rd(2'd1, d); chk("R2 adv readback", d, 16'h0021);
    tick(5);
    chk("R2 link unchanged", {link_up, speed_100, full_duplex}, 3'b111);

    // R3: restart bit reads 1 once then clears; R4 break wait
    wr(2'd0, 16'h1200);
    rd(2'd0, d); chk("R3 bit9 set", d, 16'h1200);
    tick(1);
    rd(2'd0, d); chk("R3 bit9 self-clear", d, 16'h1000);
    chk("R4 link low early", {link_up, traffic_en}, 2'b00);
    tick(N - 1);
    chk("R4 link low at end of wait", {link_up, traffic_en}, 2'b00);
    tick(2);
    chk("R3 new adv used 10H", {link_up, speed_100, full_duplex}, 3'b100);
    chk("R4 traffic after wait", traffic_en, 1);

    // R5 random sweep
    for (int k = 0; k < 40; k++) begin
      adv = 4'($urandom);
      w = 16'($urandom);
      flp_word = w;
      wr(2'd1, {7'd0, adv, 5'd1});
      restart_and_wait();
      e = expect_res(adv, w[8:5]);
      chk("R5 resolve", {link_up, speed_100, full_duplex}, {e[2], e[2] ? e[1:0] : {speed_100, full_duplex}});
      rd(2'd2, d); chk("R6 partner", d, {1'b0, w[14:0]});
    end

    // R7 parallel detection
    wr(2'd1, 16'h01E1);
    flp_valid = 1'b0;
    idle100_seen = 1'b1; nlp10_seen = 1'b1;
    restart_and_wait();
    chk("R7 idle wins 100H", {link_up, speed_100, full_duplex}, 3'b110);
    rd(2'd2, d); chk("R7 partner 100", d, 16'h0080);
    rd(2'd3, d); chk("R7 status", d, 16'h0000);
    idle100_seen = 1'b0;
    restart_and_wait();
    chk("R7 10H", {link_up, speed_100, full_duplex}, 3'b100);
    rd(2'd2, d); chk("R7 partner 10", d, 16'h0020);

    // R7/R8 random mixes
    for (int k = 0; k < 20; k++) begin
      pd_fault = 1'($urandom); idle100_seen = 1'($urandom); nlp10_seen = 1'($urandom);
      restart_and_wait();
      rd(2'd3, d);
      if (pd_fault) begin
        chk("R8 fault keeps down", link_up, 0);
        chk("R8 fault bit", d[4], 1);
      end else if (idle100_seen || nlp10_seen) begin
        chk("R7 pd link", {link_up, speed_100, full_duplex}, {1'b1, idle100_seen, 1'b0});
        chk("R8 no fault bit", d[4], 0);
      end else begin
        chk("R7 nothing seen", link_up, 0);
      end
    end
    // R8 sticky until restart
    pd_fault = 1'b1; idle100_seen = 1'b0; nlp10_seen = 1'b0;
    restart_and_wait();
    pd_fault = 1'b0;
    tick(3);
    rd(2'd3, d); chk("R8 sticky", d[4], 1);
    wr(2'd0, 16'h1200);
    tick(2);
    rd(2'd3, d); chk("R8 cleared by restart", d[4], 0);
    tick(N + 2);

    // R9 signal loss
    flp_word = 16'h01E1; flp_valid = 1'b1;
    restart_and_wait();
    chk("R9 up before loss", link_up, 1);
    signal_present = 1'b0;
    tick(1);
    signal_present = 1'b1;
    chk("R9 down after loss", link_up, 0);
    tick(N - 2);
    chk("R9 still waiting", link_up, 0);
    tick(4);
    chk("R9 back up", {link_up, speed_100, full_duplex}, 3'b111);

    // R10 forced mode
    wr(2'd0, 16'h2100);
    chk("R10 forced 100F", {link_up, speed_100, full_duplex}, 3'b111);
    wr(2'd0, 16'h0000);
    chk("R10 forced 10H", {link_up, speed_100, full_duplex}, 3'b100);
    signal_present = 1'b0;
    #1;
    chk("R10 link follows signal", {link_up, traffic_en}, 2'b00);
    signal_present = 1'b1;
    tick(1);

    // R11 re-enable restarts
    wr(2'd0, 16'h1000);
    tick(2);
    chk("R11 in break", link_up, 0);
    tick(N);
    chk("R11 negotiated again", {link_up, speed_100, full_duplex}, 3'b111);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule